// File: doc/BRIEF.md
# Macro Method-Stream Front End

This block sits between an upstream command fetcher and a downstream method dispatcher. Each accepted beat is a (method, data) pair. The method is a byte address that is normally word aligned. A small fixed set of method addresses is decoded and handled here, and every other beat goes to the dispatcher unchanged. The decoded methods do four things. They fill a 2048-word code store through an auto-incrementing upload pointer. They bind one of 32 macro slots to a start address in that store. They launch a slot on an external macro execution core. They feed extra parameters to the running macro through a small in-order queue.

Both stream edges use valid/ready. Upstream is held off in three cases: while the dispatcher is not ready for a pass-through beat, while a launch targets a core that reports busy, and while the parameter queue is full. A held beat must stay stable until it is accepted. The core side is plain control: the core reads the code store through a synchronous read port, pops parameters, and signals when it is waiting for a parameter and when the macro has finished. The block raises a one-cycle trap in two cases: a macro ends with parameters still queued, or a non-parameter method arrives while the core is starved for a parameter.

Top module: `macro_frontend`

## Requirements
- R1: After reset, dn_valid, core_start, trap_valid and core_param_avail are 0. Every slot binding is 0, so a launch of a slot that was never bound starts at code address 0.
- R2: An accepted beat to method 0x0114 loads the upload pointer from data bits 10:0.
- R3: An accepted beat to method 0x0118 writes the data word to the code store at the upload pointer, then adds one to the pointer. The pointer wraps from 0x7FF to 0x000. Code read data appears on code_rdata one clock after code_raddr is presented.
- R4: Method 0x011C selects the slot from data bits 4:0. Method 0x0120 binds the selected slot to start address data bits 10:0.
- R5: Method 0x3800+8*i, for i from 0 to 31, launches slot i. In the cycle the beat is accepted, core_start is 1, core_start_pc holds the slot's binding and core_arg holds the data. While core_busy is 1 the beat is not accepted and core_start stays 0.
- R6: Method 0x3804+8*i, for i from 0 to 31, pushes the data into a 4-entry parameter queue. The queue is read in arrival order through core_param_data, core_param_avail and core_param_pop. Upstream stalls while the queue is full.
- R7: Every method not listed in R2 to R6 is forwarded with its address and data unchanged. This includes launch-window addresses with bits 1:0 not zero, and addresses at or above 0x3900. up_ready follows dn_ready for such beats.
- R8: If core_done is 1 while a parameter is queued, or is being queued in that cycle, trap_valid is 1 in the next cycle with trap_cause bit 0 set, and the queue is emptied.
- R9: If core_param_wait is 1, the queue is empty and a beat other than R6 is presented, the beat is accepted and discarded. It does not reach the dispatcher and starts no macro. trap_valid is 1 in the next cycle with trap_cause bit 1 set.
- R10: Beats handled by R2 to R6 never assert dn_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream beat valid |
| up_ready | output | 1 | Upstream beat accepted this cycle when valid |
| up_mthd | input | 16 | Upstream method byte address |
| up_data | input | 32 | Upstream method data |
| dn_valid | output | 1 | Forwarded beat valid |
| dn_ready | input | 1 | Dispatcher can take a beat |
| dn_mthd | output | 16 | Forwarded method address |
| dn_data | output | 32 | Forwarded data |
| core_busy | input | 1 | Core is running a macro |
| core_start | output | 1 | Launch strobe |
| core_start_pc | output | 11 | Start address of launched slot |
| core_arg | output | 32 | Launch argument |
| core_param_wait | input | 1 | Core is stalled on a parameter read |
| core_param_pop | input | 1 | Core consumes the head parameter |
| core_param_avail | output | 1 | Queue holds a parameter |
| core_param_data | output | 32 | Head parameter |
| core_done | input | 1 | Macro finished this cycle |
| code_raddr | input | 11 | Code store read address |
| code_rdata | output | 32 | Code store read data, one cycle later |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_cause | output | 2 | Bit 0 leftover parameter, bit 1 unexpected method |

## Verification
Several rules are checked by the assertions on every cycle. A forwarded beat always has a valid upstream beat behind it. A launch never reaches a busy core. A queued parameter stays available until it is popped or flushed. Each accepted 0x0118 beat advances the upload pointer by exactly one. A finishing macro with a queued parameter produces a leftover trap, and a starved core presented with a foreign method sees neither forwarding nor a launch. Other behaviour only shows in the bench's scenarios: that stored code words land at the right, wrapped addresses, that bindings reach the launch port, that parameters come out in arrival order, and that the dispatcher sees exactly the pass-through beats with their values intact.

// File: rtl/mf_pkg.sv
package mf_pkg;
  typedef enum logic [2:0] {
    MC_PASS,
    MC_UPL_ADDR,
    MC_UPL_DATA,
    MC_BIND_SEL,
    MC_BIND_SET,
    MC_LAUNCH,
    MC_PARAM
  } mcls_e;

  localparam logic [15:0] MTH_UPL_ADDR = 16'h0114;
  localparam logic [15:0] MTH_UPL_DATA = 16'h0118;
  localparam logic [15:0] MTH_BIND_SEL = 16'h011C;
  localparam logic [15:0] MTH_BIND_SET = 16'h0120;
  localparam logic [15:0] MTH_LAUNCH0  = 16'h3800;

  localparam logic [1:0] TRAP_LEFTOVER   = 2'b01;
  localparam logic [1:0] TRAP_UNEXPECTED = 2'b10;
endpackage

// File: rtl/mf_decode.sv
module mf_decode
  import mf_pkg::*;
#(
  parameter int MTHD_W = 16,
  parameter int SLOTS  = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic [MTHD_W-1:0] mthd,
  output mcls_e             cls,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [MTHD_W-1:0] BASE = MTHD_W'(MTH_LAUNCH0);
  localparam logic [MTHD_W-1:0] WIN  = MTHD_W'(SLOTS * 8);

  logic [MTHD_W-1:0] offset;
  logic              in_win;

  always_comb begin
    offset = mthd - BASE;
    in_win = (mthd >= BASE) && (offset < WIN) && (offset[1:0] == 2'b00);
    slot   = offset[3 +: SLOT_W];
    if (mthd == MTHD_W'(MTH_UPL_ADDR))      cls = MC_UPL_ADDR;
    else if (mthd == MTHD_W'(MTH_UPL_DATA)) cls = MC_UPL_DATA;
    else if (mthd == MTHD_W'(MTH_BIND_SEL)) cls = MC_BIND_SEL;
    else if (mthd == MTHD_W'(MTH_BIND_SET)) cls = MC_BIND_SET;
    else if (in_win)                        cls = offset[2] ? MC_PARAM : MC_LAUNCH;
    else                                    cls = MC_PASS;
  end
endmodule

// File: rtl/mf_code_mem.sv
module mf_code_mem #(
  parameter int DEPTH = 2048,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mf_bind_table.sv
module mf_bind_table #(
  parameter int SLOTS = 32,
  parameter int AW    = 11,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [SLOT_W-1:0] sel_in,
  input  logic              bind_we,
  input  logic [AW-1:0]     bind_pc,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [AW-1:0]     rd_pc
);
  logic [SLOT_W-1:0] sel_q;
  logic [AW-1:0]     tbl [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= sel_in;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                   tbl[s] <= '0;
      else if (bind_we && (sel_q == SLOT_W'(s)))    tbl[s] <= bind_pc;
    end
  end

  assign rd_pc = tbl[rd_slot];
endmodule

// File: rtl/mf_param_fifo.sv
module mf_param_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] dout,
  output logic          avail,
  output logic          full
);
  logic [DW-1:0] buf_q [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  assign avail = (cnt != '0);
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign dout  = buf_q[rp];

  always_ff @(posedge clk) begin
    if (push && !full) buf_q[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && avail)  rp <= rp + 1'b1;
      cnt <= cnt + (PW+1)'(push && !full) - (PW+1)'(pop && avail);
    end
  end
endmodule

// File: rtl/macro_frontend.sv
module macro_frontend
  import mf_pkg::*;
#(
  parameter int MTHD_W     = 16,
  parameter int DW         = 32,
  parameter int CODE_DEPTH = 2048,
  parameter int SLOTS      = 32,
  parameter int PQ_DEPTH   = 4,
  localparam int CODE_AW   = $clog2(CODE_DEPTH),
  localparam int SLOT_W    = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_valid,
  output logic               up_ready,
  input  logic [MTHD_W-1:0]  up_mthd,
  input  logic [DW-1:0]      up_data,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [MTHD_W-1:0]  dn_mthd,
  output logic [DW-1:0]      dn_data,
  input  logic               core_busy,
  output logic               core_start,
  output logic [CODE_AW-1:0] core_start_pc,
  output logic [DW-1:0]      core_arg,
  input  logic               core_param_wait,
  input  logic               core_param_pop,
  output logic               core_param_avail,
  output logic [DW-1:0]      core_param_data,
  input  logic               core_done,
  input  logic [CODE_AW-1:0] code_raddr,
  output logic [DW-1:0]      code_rdata,
  output logic               trap_valid,
  output logic [1:0]         trap_cause
);
  mcls_e              cls;
  logic [SLOT_W-1:0]  slot;
  logic               unexp, fire, push, full, leftover;
  logic [CODE_AW-1:0] upl_ptr;

  mf_decode #(.MTHD_W(MTHD_W), .SLOTS(SLOTS)) u_dec (
    .mthd(up_mthd), .cls(cls), .slot(slot)
  );

  // Starved core plus a non-parameter beat: swallow it and trap.
  assign unexp = up_valid && core_param_wait && !core_param_avail && (cls != MC_PARAM);

  always_comb begin
    if (unexp) up_ready = 1'b1;
    else begin
      unique case (cls)
        MC_PASS:   up_ready = dn_ready;
        MC_LAUNCH: up_ready = !core_busy;
        MC_PARAM:  up_ready = !full;
        default:   up_ready = 1'b1;
      endcase
    end
  end

  assign fire       = up_valid && up_ready && !unexp;
  assign dn_valid   = up_valid && (cls == MC_PASS) && !unexp;
  assign dn_mthd    = up_mthd;
  assign dn_data    = up_data;
  assign core_start = fire && (cls == MC_LAUNCH);
  assign core_arg   = up_data;
  assign push       = fire && (cls == MC_PARAM);
  assign leftover   = core_done && (core_param_avail || push);

  always_ff @(posedge clk) begin
    if (!rst_n)                             upl_ptr <= '0;
    else if (fire && cls == MC_UPL_ADDR)    upl_ptr <= up_data[CODE_AW-1:0];
    else if (fire && cls == MC_UPL_DATA)    upl_ptr <= upl_ptr + 1'b1;
  end

  mf_code_mem #(.DEPTH(CODE_DEPTH), .DW(DW)) u_mem (
    .clk(clk), .we(fire && cls == MC_UPL_DATA), .waddr(upl_ptr), .wdata(up_data),
    .raddr(code_raddr), .rdata(code_rdata)
  );

  mf_bind_table #(.SLOTS(SLOTS), .AW(CODE_AW)) u_bind (
    .clk(clk), .rst_n(rst_n),
    .sel_we(fire && cls == MC_BIND_SEL), .sel_in(up_data[SLOT_W-1:0]),
    .bind_we(fire && cls == MC_BIND_SET), .bind_pc(up_data[CODE_AW-1:0]),
    .rd_slot(slot), .rd_pc(core_start_pc)
  );

  mf_param_fifo #(.DEPTH(PQ_DEPTH), .DW(DW)) u_pq (
    .clk(clk), .rst_n(rst_n), .push(push), .din(up_data),
    .pop(core_param_pop), .flush(core_done),
    .dout(core_param_data), .avail(core_param_avail), .full(full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_cause <= '0;
    end else begin
      trap_valid <= leftover || unexp;
      trap_cause <= (leftover ? TRAP_LEFTOVER : 2'b00) | (unexp ? TRAP_UNEXPECTED : 2'b00);
    end
  end
endmodule

// File: rtl/macro_frontend_chk.sv
module macro_frontend_chk #(
  parameter int MTHD_W  = 16,
  parameter int CODE_AW = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               up_valid,
  input logic               up_ready,
  input logic [MTHD_W-1:0]  up_mthd,
  input logic               dn_valid,
  input logic               core_busy,
  input logic               core_start,
  input logic               core_done,
  input logic               core_param_wait,
  input logic               core_param_pop,
  input logic               core_param_avail,
  input logic               trap_valid,
  input logic [1:0]         trap_cause,
  input logic [CODE_AW-1:0] upl_ptr
);
  // R7
  fwd_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> up_valid);

  // R5
  launch_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !core_busy);

  // R6
  param_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_param_avail && !core_param_pop && !core_done |=> core_param_avail);

  // R3
  upload_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready && (up_mthd == MTHD_W'(16'h0118)) &&
    !(core_param_wait && !core_param_avail)
    |=> upl_ptr == CODE_AW'($past(upl_ptr) + 1'b1));

  // R8
  leftover_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_done && core_param_avail |=> trap_valid && trap_cause[0] && !core_param_avail);

  // R9
  starved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && core_param_wait && !core_param_avail |-> !dn_valid && !core_start);
endmodule

bind macro_frontend macro_frontend_chk #(.MTHD_W(MTHD_W), .CODE_AW(CODE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready), .up_mthd(up_mthd),
  .dn_valid(dn_valid), .core_busy(core_busy), .core_start(core_start),
  .core_done(core_done), .core_param_wait(core_param_wait),
  .core_param_pop(core_param_pop), .core_param_avail(core_param_avail),
  .trap_valid(trap_valid), .trap_cause(trap_cause), .upl_ptr(upl_ptr)
);

// File: tb/macro_frontend_test.sv
module macro_frontend_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_valid = 1'b0, up_ready;
  logic [15:0] up_mthd = '0;
  logic [31:0] up_data = '0;
  logic        dn_valid, dn_ready = 1'b1;
  logic [15:0] dn_mthd;
  logic [31:0] dn_data;
  logic        core_busy = 1'b0, core_start;
  logic [10:0] core_start_pc;
  logic [31:0] core_arg;
  logic        core_param_wait = 1'b0, core_param_pop = 1'b0, core_param_avail;
  logic [31:0] core_param_data;
  logic        core_done = 1'b0;
  logic [10:0] code_raddr = '0;
  logic [31:0] code_rdata;
  logic        trap_valid;
  logic [1:0]  trap_cause;

  int n_chk = 0, n_fail = 0;
  logic        c_dn_valid, c_start;
  logic [15:0] c_dn_mthd;
  logic [31:0] c_dn_data, c_arg;
  logic [10:0] c_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  macro_frontend uut (.*);

  // {method, data, expect forwarded}
  localparam logic [48:0] VEC [8] = '{
    {16'h0100, 32'h1111_0001, 1'b1},
    {16'h0114, 32'h0000_0010, 1'b0},
    {16'h0118, 32'h2222_0002, 1'b0},
    {16'h3900, 32'h3333_0003, 1'b1},
    {16'h3802, 32'h4444_0004, 1'b1},
    {16'h1A00, 32'h5555_0005, 1'b1},
    {16'h011C, 32'h0000_0001, 1'b0},
    {16'h0120, 32'h0000_0000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] m, input logic [31:0] d);
    @(negedge clk);
    up_valid = 1'b1; up_mthd = m; up_data = d;
    #1;
    while (!up_ready) begin @(negedge clk); #1; end
    c_dn_valid = dn_valid; c_dn_mthd = dn_mthd; c_dn_data = dn_data;
    c_start = core_start; c_pc = core_start_pc; c_arg = core_arg;
    @(posedge clk); #1;
    up_valid = 1'b0;
  endtask

  task automatic rd_code(input logic [10:0] a, input logic [31:0] exp);
    @(negedge clk); code_raddr = a;
    @(posedge clk); #1;
    check("R3 code word", code_rdata, exp);
  endtask

  task automatic pop_chk(input logic [31:0] exp);
    @(negedge clk);
    check("R6 param order", core_param_data, exp);
    check("R6 param avail", {31'd0, core_param_avail}, 32'd1);
    core_param_pop = 1'b1;
    @(posedge clk); #1; core_param_pop = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check("R1 dn_valid", {31'd0, dn_valid}, 32'd0);
    check("R1 core_start", {31'd0, core_start}, 32'd0);
    check("R1 trap_valid", {31'd0, trap_valid}, 32'd0);
    check("R1 param_avail", {31'd0, core_param_avail}, 32'd0);

    // R7 / R10 vector walk
    foreach (VEC[i]) begin
      send(VEC[i][48:33], VEC[i][32:1]);
      check("R7/R10 forwarded", {31'd0, c_dn_valid}, {31'd0, VEC[i][0]});
      if (VEC[i][0]) begin
        check("R7 mthd", {16'd0, c_dn_mthd}, {16'd0, VEC[i][48:33]});
        check("R7 data", c_dn_data, VEC[i][32:1]);
      end
    end
    rd_code(11'h010, 32'h2222_0002);

    // R2 / R3 upload with wrap
    send(16'h0114, 32'hFFFF_F7FE);
    send(16'h0118, 32'hA000_000A);
    send(16'h0118, 32'hB000_000B);
    send(16'h0118, 32'hC000_000C);
    rd_code(11'h7FE, 32'hA000_000A);
    rd_code(11'h7FF, 32'hB000_000B);
    rd_code(11'h000, 32'hC000_000C);

    // R4 / R5 bind and launch
    send(16'h011C, 32'h0000_0003);
    send(16'h0120, 32'h0000_0155);
    send(16'h3818, 32'h0000_CAFE);
    check("R5 start", {31'd0, c_start}, 32'd1);
    check("R4 bound pc", {21'd0, c_pc}, 32'h155);
    check("R5 arg", c_arg, 32'h0000_CAFE);
    send(16'h3838, 32'h0000_0007);
    check("R1 unbound pc", {21'd0, c_pc}, 32'h0);
    check("R5 start slot7", {31'd0, c_start}, 32'd1);

    // R5 busy stall
    core_busy = 1'b1;
    @(negedge clk); up_valid = 1'b1; up_mthd = 16'h38F8; up_data = 32'h99;
    #1;
    check("R5 stall ready", {31'd0, up_ready}, 32'd0);
    check("R5 stall start", {31'd0, core_start}, 32'd0);
    repeat (2) @(negedge clk);
    core_busy = 1'b0; #1;
    check("R5 release", {31'd0, core_start && up_ready}, 32'd1);
    @(posedge clk); #1; up_valid = 1'b0;

    // R7 downstream back-pressure
    dn_ready = 1'b0;
    @(negedge clk); up_valid = 1'b1; up_mthd = 16'h0200; up_data = 32'h77;
    #1;
    check("R7 bp ready", {31'd0, up_ready}, 32'd0);
    check("R7 bp valid", {31'd0, dn_valid}, 32'd1);
    @(negedge clk); dn_ready = 1'b1; #1;
    check("R7 bp release", {31'd0, up_ready}, 32'd1);
    @(posedge clk); #1; up_valid = 1'b0;

    // R6 queue fill, full stall, order
    send(16'h3804, 32'h0000_00A1);
    send(16'h380C, 32'h0000_00A2);
    send(16'h38FC, 32'h0000_00A3);
    send(16'h3814, 32'h0000_00A4);
    @(negedge clk); up_valid = 1'b1; up_mthd = 16'h3804; up_data = 32'hA5;
    #1;
    check("R6 full stall", {31'd0, up_ready}, 32'd0);
    up_valid = 1'b0;
    pop_chk(32'hA1); pop_chk(32'hA2); pop_chk(32'hA3); pop_chk(32'hA4);
    @(negedge clk);
    check("R6 drained", {31'd0, core_param_avail}, 32'd0);

    // R8 leftover trap
    send(16'h3804, 32'h0000_00B1);
    @(negedge clk); core_done = 1'b1;
    @(posedge clk); #1; core_done = 1'b0;
    check("R8 trap", {31'd0, trap_valid}, 32'd1);
    check("R8 cause", {30'd0, trap_cause}, 32'd1);
    check("R8 flushed", {31'd0, core_param_avail}, 32'd0);
    @(posedge clk); #1;
    check("R8 pulse", {31'd0, trap_valid}, 32'd0);

    // R9 unexpected method while starved
    core_param_wait = 1'b1;
    send(16'h0100, 32'h0000_00C1);
    check("R9 dropped", {31'd0, c_dn_valid}, 32'd0);
    check("R9 trap", {31'd0, trap_valid}, 32'd1);
    check("R9 cause", {30'd0, trap_cause}, 32'd2);
    send(16'h3804, 32'h0000_00C2);
    check("R9 param ok", {31'd0, trap_valid}, 32'd0);
    core_param_wait = 1'b0;
    pop_chk(32'hC2);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule